// File: doc/BRIEF.md
# Latched Interrupt Node Controller

This block is one interrupt node that collects a parameterised number of peripheral event sources. Each source owns a status flag and an event-enable bit. The node keeps a single pending-request latch that is kept apart from the flags. It also holds a node enable bit, a global enable bit that gates the request line to the core, and a mode bit. The mode bit chooses which enables qualify an event into the latch and how software may clear the latch.

Events arrive as one-cycle pulses. Software reaches the node through a simple write port: a strobe, a two-bit register select and a data word. Through it, software sets or clears flags, loads the event-enable bits and loads the control bits. The core returns a one-cycle acknowledge when it services the node, and the acknowledge drops the latch. The flags and the latch state can be read at all times. Priority between nodes, vector generation and the peripherals themselves lie outside this block.

All qualification is evaluated on the values that the registers take at the coming clock edge. A configuration write that lands in the same cycle as an event therefore takes part in the decision.

Top module: `irq_node_ctrl`

## Requirements
- R1: After reset, every flag, the pending latch, the event-enable bits, node enable, global enable and mode are 0, so `irq_o` is 0.
- R2: An event pulse on source i sets flag i at the next clock edge, whatever the enable and mode bits hold.
- R3: With mode = 1, an event on a source whose event-enable bit is set also sets the pending latch, even when node enable is 0.
- R4: With mode = 0, an event sets the pending latch only when its event-enable bit and node enable are both 1.
- R5: `irq_o` equals the pending latch ANDed with the global enable bit, with no added delay.
- R6: An acknowledge clears the pending latch at the next edge and leaves every flag unchanged.
- R7: Software never sets the pending latch. Flag-set writes, enable writes and control writes alone leave it at 0; only a qualified event raises it.
- R8: With mode = 1, the pending latch clears at the same edge at which no flag that is also event-enabled remains set. Flags whose enable is 0 do not hold it.
- R9: With mode = 0, writing node enable to 0 clears the pending latch at that edge. The flags are untouched.
- R10: An event that qualifies for the latch in the same cycle as an acknowledge wins, and the latch stays set.
- R11: A software clear of a flag in the same cycle as an event on that flag leaves the flag set. Other flags in the same clear still clear.
- R12: Register select encoding: 0 clears the flags whose data bits are 1; 1 sets the flags whose data bits are 1; 2 loads the event-enable bits from data[NUM_SRC-1:0]; 3 loads control, with data bit 0 = node enable, bit 1 = mode and bit 2 = global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_SRC | One-cycle event pulses, one per source |
| wr_i | input | 1 | Software write strobe |
| sel_i | input | 2 | Register select (see R12) |
| wdata_i | input | DATA_W | Software write data |
| ack_i | input | 1 | Interrupt acknowledge from the core |
| irq_o | output | 1 | Request line to the core |
| flags_o | output | NUM_SRC | Current status flags |
| pending_o | output | 1 | Current pending latch |

## Verification
The embedded assertions watch, on every cycle, the rules that hold from state to state. An event always leaves its flag set. The latch rises only after a qualified event. An acknowledge without a competing event drops the latch, and a competing event keeps it. While the latch is set in mode 1, an event-enabled flag is set; while it is set in mode 0, node enable is 1. The bench scenarios add what a property cannot show on its own: the register select encoding, the difference between the two modes when node enable is 0, the exact edge at which the latch clears after a flag clear or a node disable, and that software writes alone never raise a request.

// File: rtl/irq_node_pkg.sv
package irq_node_pkg;

  typedef enum logic [1:0] {
    SEL_FLAG_CLR = 2'd0,
    SEL_FLAG_SET = 2'd1,
    SEL_EVT_EN   = 2'd2,
    SEL_CTRL     = 2'd3
  } reg_sel_e;

  localparam int CTRL_NODE_EN_BIT = 0;
  localparam int CTRL_MODE_BIT    = 1;
  localparam int CTRL_GLOBAL_BIT  = 2;
  localparam int CTRL_W           = 3;

  // Does any enabled event qualify for the pending latch this cycle?
  function automatic logic pend_set_fn(input logic evt_hit,
                                       input logic node_en,
                                       input logic mode);
    if (mode) pend_set_fn = evt_hit;
    else      pend_set_fn = evt_hit & node_en;
  endfunction

  // Indirect software clear condition for the pending latch.
  function automatic logic pend_clr_fn(input logic qual_any,
                                       input logic node_en,
                                       input logic mode);
    if (mode) pend_clr_fn = ~qual_any;
    else      pend_clr_fn = ~node_en;
  endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_node_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic [1:0]         sel_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [NUM_SRC-1:0] en_d,
  output logic [NUM_SRC-1:0] en_q,
  output logic               node_en_d,
  output logic               node_en_q,
  output logic               mode_d,
  output logic               mode_q,
  output logic               gen_q
);

  logic wr_en, wr_ctrl, gen_d;

  assign wr_en   = wr_i && (reg_sel_e'(sel_i) == SEL_EVT_EN);
  assign wr_ctrl = wr_i && (reg_sel_e'(sel_i) == SEL_CTRL);

  always_comb begin
    en_d      = en_q;
    node_en_d = node_en_q;
    mode_d    = mode_q;
    gen_d     = gen_q;
    if (wr_en) en_d = wdata_i[NUM_SRC-1:0];
    if (wr_ctrl) begin
      node_en_d = wdata_i[CTRL_NODE_EN_BIT];
      mode_d    = wdata_i[CTRL_MODE_BIT];
      gen_d     = wdata_i[CTRL_GLOBAL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      node_en_q <= 1'b0;
      mode_q    <= 1'b0;
      gen_q     <= 1'b0;
    end else begin
      en_q      <= en_d;
      node_en_q <= node_en_d;
      mode_q    <= mode_d;
      gen_q     <= gen_d;
    end
  end

  // R12: control write lands at the next edge
  p_ctrl_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (mode_q == $past(wdata_i[CTRL_MODE_BIT])) &&
                (node_en_q == $past(wdata_i[CTRL_NODE_EN_BIT])));

endmodule

// File: rtl/irq_src_slice.sv
module irq_src_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic sw_clr_i,
  input  logic sw_set_i,
  output logic flag_d,
  output logic flag_q
);

  // Event and software set both beat a software clear (R11).
  assign flag_d = evt_i | sw_set_i | (flag_q & ~sw_clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  // R2: event always sets the flag
  p_evt_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> flag_q);

  // R11: clear without event or set drops the flag
  p_clr_drops_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr_i && !evt_i && !sw_set_i) |=> !flag_q);

endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic ack_i,
  output logic pend_q
);

  logic pend_d;

  // Set wins over both acknowledge and indirect clear (R10).
  always_comb begin
    pend_d = pend_q;
    if (ack_i || clr_i) pend_d = 1'b0;
    if (set_i)          pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  // R7: latch only rises after a qualified event
  p_rise_needs_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(set_i));

  // R6: acknowledge with no competing event drops the latch
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !set_i) |=> !pend_q);

  // R10: event beats acknowledge
  p_evt_wins_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && set_i) |=> pend_q);

endmodule

// File: rtl/irq_node_ctrl.sv
module irq_node_ctrl
  import irq_node_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = (NUM_SRC > CTRL_W) ? NUM_SRC : CTRL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               wr_i,
  input  logic [1:0]         sel_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               ack_i,
  output logic               irq_o,
  output logic [NUM_SRC-1:0] flags_o,
  output logic               pending_o
);

  logic [NUM_SRC-1:0] en_d, en_q;
  logic               node_en_d, node_en_q, mode_d, mode_q, gen_q;
  logic [NUM_SRC-1:0] flag_d, flag_q;
  logic [NUM_SRC-1:0] evt_qual;
  logic               evt_hit, qual_any_d, pend_set, pend_clr, pend_q;
  logic               wr_clr, wr_set;

  irq_cfg_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .sel_i(sel_i), .wdata_i(wdata_i),
    .en_d(en_d), .en_q(en_q), .node_en_d(node_en_d), .node_en_q(node_en_q),
    .mode_d(mode_d), .mode_q(mode_q), .gen_q(gen_q)
  );

  assign wr_clr = wr_i && (reg_sel_e'(sel_i) == SEL_FLAG_CLR);
  assign wr_set = wr_i && (reg_sel_e'(sel_i) == SEL_FLAG_SET);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    irq_src_slice u_slice (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i[i]),
      .sw_clr_i(wr_clr && wdata_i[i]), .sw_set_i(wr_set && wdata_i[i]),
      .flag_d(flag_d[i]), .flag_q(flag_q[i])
    );
  end

  // Qualification uses next-state configuration and flags.
  assign evt_qual   = evt_i & en_d;
  assign evt_hit    = |evt_qual;
  assign qual_any_d = |(flag_d & en_d);
  assign pend_set   = pend_set_fn(evt_hit, node_en_d, mode_d);
  assign pend_clr   = pend_clr_fn(qual_any_d, node_en_d, mode_d);

  irq_pend_latch u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(pend_set), .clr_i(pend_clr),
    .ack_i(ack_i), .pend_q(pend_q)
  );

  assign irq_o     = pend_q & gen_q;
  assign flags_o   = flag_q;
  assign pending_o = pend_q;

  // R8: in mode 1 a set latch always has an enabled flag behind it
  p_mode1_backed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && mode_q) |-> |(flag_q & en_q));

  // R9: in mode 0 a set latch implies node enable
  p_mode0_backed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !mode_q) |-> node_en_q);

  // R5: global enable gates the request
  p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_q |-> !irq_o);

  // R4: mode 0 with node disabled never raises the latch
  p_mode0_needs_node_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_d && !node_en_d && !pend_q) |=> !pend_q);

endmodule

// File: tb/irq_node_ctrl_tb.sv
module irq_node_ctrl_tb;
  localparam int N  = 4;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  evt = '0;
  logic          wr = 1'b0;
  logic [1:0]    sel = '0;
  logic [DW-1:0] wdata = '0;
  logic          ack = 1'b0;
  logic          irq;
  logic [N-1:0]  flags;
  logic          pend;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  irq_node_ctrl #(.NUM_SRC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_i(wr), .sel_i(sel),
    .wdata_i(wdata), .ack_i(ack), .irq_o(irq), .flags_o(flags), .pending_o(pend)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle of stimulus; outputs sampled 1 ns after the edge.
  task automatic drive(input logic [N-1:0] e, input logic w, input logic [1:0] s,
                       input logic [DW-1:0] d, input logic a);
    @(negedge clk);
    evt = e; wr = w; sel = s; wdata = d; ack = a;
    @(posedge clk); #1;
    evt = '0; wr = 1'b0; sel = '0; wdata = '0; ack = 1'b0;
  endtask

  task automatic wreg(input logic [1:0] s, input logic [DW-1:0] d);
    drive('0, 1'b1, s, d, 1'b0);
  endtask

  task automatic event_only(input logic [N-1:0] e);
    drive(e, 1'b0, 2'd0, '0, 1'b0);
  endtask

  task automatic cleanup();
    wreg(2'd3, 4'b0000);
    wreg(2'd2, 4'b0000);
    wreg(2'd0, 4'b1111);
    drive('0, 1'b0, 2'd0, '0, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 flags", flags, 0);
    chk("R1 pending", pend, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_flag_any();
    event_only(4'b0101);
    chk("R2 flags set with enables off", flags, 4'b0101);
    chk("R4 no pending with enables off", pend, 0);
    wreg(2'd0, 4'b0001);
    chk("R12 W1C one bit", flags, 4'b0100);
    cleanup();
  endtask

  task automatic t_mode1();
    wreg(2'd3, 4'b0010);
    wreg(2'd2, 4'b0010);
    event_only(4'b0001);
    chk("R3 disabled source no pending", pend, 0);
    event_only(4'b0010);
    chk("R3 enabled source pending, node off", pend, 1);
    chk("R5 irq low with global off", irq, 0);
    chk("R2 flags", flags, 4'b0011);
    drive('0, 1'b0, 2'd0, '0, 1'b1);
    chk("R6 ack clears pending", pend, 0);
    chk("R6 flags kept on ack", flags, 4'b0011);
    cleanup();
  endtask

  task automatic t_mode0();
    wreg(2'd3, 4'b0000);
    wreg(2'd2, 4'b0010);
    event_only(4'b0010);
    chk("R4 node off no pending", pend, 0);
    wreg(2'd0, 4'b1111);
    wreg(2'd3, 4'b0001);
    event_only(4'b0100);
    chk("R4 source not enabled no pending", pend, 0);
    event_only(4'b0010);
    chk("R4 both enables pending", pend, 1);
    wreg(2'd3, 4'b0101);
    chk("R5 irq with global on", irq, 1);
    wreg(2'd3, 4'b0001);
    chk("R5 irq off with global off", irq, 0);
    chk("R5 pending kept", pend, 1);
    cleanup();
  endtask

  task automatic t_sw_no_set();
    wreg(2'd3, 4'b0111);
    wreg(2'd2, 4'b1111);
    wreg(2'd1, 4'b1111);
    chk("R12 W1S flags", flags, 4'b1111);
    chk("R7 W1S no pending", pend, 0);
    wreg(2'd3, 4'b0101);
    wreg(2'd2, 4'b0011);
    chk("R7 config writes no pending", pend, 0);
    chk("R7 irq stays low", irq, 0);
    cleanup();
  endtask

  task automatic t_mode1_clear();
    wreg(2'd3, 4'b0010);
    wreg(2'd2, 4'b0011);
    event_only(4'b0011);
    chk("R8 pending set", pend, 1);
    wreg(2'd0, 4'b0001);
    chk("R8 one enabled flag left, pending held", pend, 1);
    wreg(2'd0, 4'b0010);
    chk("R8 last enabled flag cleared, pending clears", pend, 0);
    event_only(4'b0101);
    chk("R8 pending again", pend, 1);
    wreg(2'd0, 4'b0001);
    chk("R8 non-enabled flag does not hold", pend, 0);
    chk("R8 non-enabled flag kept", flags, 4'b0100);
    cleanup();
  endtask

  task automatic t_mode0_clear();
    wreg(2'd3, 4'b0001);
    wreg(2'd2, 4'b0001);
    event_only(4'b0001);
    chk("R9 pending set", pend, 1);
    wreg(2'd3, 4'b0000);
    chk("R9 node disable clears pending", pend, 0);
    chk("R9 flags untouched", flags, 4'b0001);
    cleanup();
  endtask

  task automatic t_evt_vs_ack();
    wreg(2'd3, 4'b0001);
    wreg(2'd2, 4'b0001);
    event_only(4'b0001);
    drive(4'b0001, 1'b0, 2'd0, '0, 1'b1);
    chk("R10 event beats ack", pend, 1);
    drive('0, 1'b0, 2'd0, '0, 1'b1);
    chk("R10 later ack clears", pend, 0);
    cleanup();
  endtask

  task automatic t_evt_vs_clr();
    event_only(4'b0010);
    drive(4'b0001, 1'b1, 2'd0, 4'b0011, 1'b0);
    chk("R11 event beats clear, other bit clears", flags, 4'b0001);
    drive(4'b0001, 1'b1, 2'd0, 4'b0001, 1'b0);
    chk("R11 held flag survives clear with event", flags, 4'b0001);
    cleanup();
    chk("R11 cleanup", flags, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_flag_any();
    t_mode1();
    t_mode0();
    t_sw_no_set();
    t_mode1_clear();
    t_mode0_clear();
    t_evt_vs_ack();
    t_evt_vs_clr();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule